// File: doc/BRIEF.md
# Pipeline Interlock Hazard Detector

This block detects read-after-write dependencies in a five-stage in-order pipeline and stalls the pipeline until they clear. The five stages are instruction fetch, address computation (AC), operand fetch (OF), operate (OP) and operand store (OS). Instructions are offered at the fetch edge. A small harness of interstage registers carries each accepted instruction down the pipe. Every slot has a valid bit.

Comparators check the instruction waiting in OF against the write predictions of OP and OS. They look at register numbers and at effective addresses. A second set of comparators checks the index register of the instruction in AC against every writer further down the pipe.

There are two interlocks:
- The operand interlock freezes fetch, AC and OF and drops a bubble into OP.
- The index interlock freezes only fetch and AC and drops a bubble into OF.

Writes in OS take effect at the clock edge, so a dependent instruction moves forward in the cycle after its producer leaves OS. The result is as if the compiler had placed the needed no-op slots.

Top module: `ilk_pipe`

## Requirements
- R1: After reset all four slot valid bits are 0, `in_ready` is 1 and both freeze outputs are 0.
- R2: With no hazard, an instruction accepted at a clock edge occupies AC, OF, OP and OS on the next four cycles, one stage per cycle. The OS slot always takes the OP slot's content at every edge.
- R3: Instruction word layout is alu [31:28], mode [27:24], r [23:20], x [19:16], disp [15:0]; the effective address equals disp. Mode bit 3 means "reads register r", bit 2 "reads memory at ea", bit 1 "writes register r", bit 0 "writes memory at ea". The operand interlock fires when the OF instruction reads register r and a valid OP instruction writes that same r.
- R4: The operand interlock also fires when the OF instruction reads register r and a valid OS instruction writes that r.
- R5: The operand interlock also fires when the OF instruction reads memory and a valid OP or OS instruction writes memory at the same ea.
- R6: While the operand interlock is active, `of_freeze` is 1 and `in_ready` is 0. At the next edge AC and OF keep their contents, OP receives a bubble and OS receives the old OP content.
- R7: The index interlock fires when a valid AC instruction has a nonzero x and a valid OF, OP or OS instruction writes register x. It raises `ac_freeze`, lowers `in_ready`, holds AC, puts a bubble into OF and advances OF to OP and OP to OS.
- R8: An x field of 0 means no indexing and never raises the index interlock.
- R9: When both interlocks would fire in the same cycle, only `of_freeze` is raised and the operand-interlock behaviour applies.
- R10: Bubbles and cycles without `in_valid` become slots with valid 0 and mode 0000. Such slots never assert an OS write and never cause a stall, whatever the offered word contains.
- R11: A register load followed directly by a store that reads the same register gives exactly two operand-interlock cycles. With one independent instruction between them it gives exactly one.
- R12: Instructions whose register numbers and addresses do not match flow through with no freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered at fetch |
| in_instr | input | 32 | Offered instruction word |
| in_ready | output | 1 | The offered instruction is taken at this edge |
| of_freeze | output | 1 | Operand interlock active (fetch, AC, OF held) |
| ac_freeze | output | 1 | Index interlock active (fetch, AC held) |
| stage_valid | output | 4 | Slot valid bits: bit 0 AC, 1 OF, 2 OP, 3 OS |
| os_alu | output | 4 | ALU field of the OS slot |
| os_mode | output | 4 | Mode field of the OS slot |
| os_r | output | 4 | Register field of the OS slot |
| os_x | output | 4 | Index field of the OS slot |
| os_ea | output | 16 | Effective address of the OS slot |
| os_wr_reg | output | 1 | OS writes register `os_r` this cycle |
| os_wr_mem | output | 1 | OS writes memory at `os_ea` this cycle |

## Verification
The bench aims at the release cycle. A load followed directly by a dependent store must give two stall cycles. A detector that kept the OS comparison for one cycle too many would give three, and one that left it out would give one.

The bench also sends an indexed instruction right behind the producer of its index register. A detector that compared x against OP and OS only would let it through one cycle early.

Other cases:
- A cycle in which both interlocks hold at once. A detector without the priority would raise both freezes and lose the OF slot to a bubble.
- A zero index behind a write to register 0.
- Invalid offered words whose mode bits look like writes. Treating these as real would show up as unexpected stalls.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    parameter int ALU_W  = 4;
    parameter int MODE_W = 4;
    parameter int REG_W  = 4;
    parameter int EA_W   = 16;
    localparam int INSTR_W = ALU_W + MODE_W + 2 * REG_W + EA_W;
    localparam int NSLOT   = 4;   // AC, OF, OP, OS
    localparam int NDN     = 3;   // writer slots downstream of AC
    localparam int NMEM    = NDN - 1; // writer slots downstream of OF

    // mode bit positions
    localparam int B_RD_REG = 3;
    localparam int B_RD_MEM = 2;
    localparam int B_WR_REG = 1;
    localparam int B_WR_MEM = 0;

    typedef struct packed {
        logic              vld;
        logic [ALU_W-1:0]  alu;
        logic [MODE_W-1:0] mode;
        logic [REG_W-1:0]  r;
        logic [REG_W-1:0]  x;
        logic [EA_W-1:0]   ea;
    } slot_t;

    typedef struct packed {
        slot_t ac;
        slot_t of;
        slot_t op;
        slot_t os;
    } pipe_t;

    typedef enum logic [1:0] {
        ADV_ALL     = 2'd0,
        ADV_AC_HOLD = 2'd1,
        ADV_OF_HOLD = 2'd2
    } adv_e;

    localparam slot_t BUBBLE = '0;

    function automatic slot_t unpack_instr(input logic [INSTR_W-1:0] w);
        slot_t s;
        s.vld  = 1'b1;
        s.ea   = w[EA_W-1:0];
        s.x    = w[EA_W +: REG_W];
        s.r    = w[EA_W + REG_W +: REG_W];
        s.mode = w[EA_W + 2 * REG_W +: MODE_W];
        s.alu  = w[INSTR_W-1 -: ALU_W];
        return s;
    endfunction
endpackage

// File: rtl/ilk_wr_match.sv
module ilk_wr_match #(
    parameter int TAG_W = 4
) (
    input  logic             en,
    input  logic [TAG_W-1:0] tag,
    input  logic [TAG_W-1:0] probe,
    output logic             hit
);
    always_comb begin
        hit = en && (tag == probe);
    end
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
(
    input  logic                       ac_need_idx,
    input  logic [REG_W-1:0]           ac_x,
    input  logic                       of_need_reg,
    input  logic                       of_need_mem,
    input  logic [REG_W-1:0]           of_r,
    input  logic [EA_W-1:0]            of_ea,
    input  logic [NDN-1:0]             wr_reg,
    input  logic [NDN-1:0][REG_W-1:0]  reg_tag,
    input  logic [NMEM-1:0]            wr_mem,
    input  logic [NMEM-1:0][EA_W-1:0]  mem_tag,
    output logic                       of_hit,
    output logic                       ac_hit
);
    logic [NDN-1:0]  idx_hit;
    logic [NDN-1:0]  reg_hit;
    logic [NMEM-1:0] mem_hit;

    for (genvar k = 0; k < NDN; k++) begin : g_dn
        ilk_wr_match #(.TAG_W(REG_W)) u_idx (
            .en    (wr_reg[k]),
            .tag   (reg_tag[k]),
            .probe (ac_x),
            .hit   (idx_hit[k])
        );
        if (k == 0) begin : g_self
            assign reg_hit[k] = 1'b0;
        end else begin : g_later
            ilk_wr_match #(.TAG_W(REG_W)) u_reg (
                .en    (wr_reg[k]),
                .tag   (reg_tag[k]),
                .probe (of_r),
                .hit   (reg_hit[k])
            );
            ilk_wr_match #(.TAG_W(EA_W)) u_mem (
                .en    (wr_mem[k-1]),
                .tag   (mem_tag[k-1]),
                .probe (of_ea),
                .hit   (mem_hit[k-1])
            );
        end
    end

    always_comb begin
        of_hit = (of_need_reg && (|reg_hit)) || (of_need_mem && (|mem_hit));
        ac_hit = ac_need_idx && (|idx_hit);
    end
endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
    import ilk_pkg::*;
(
    input  logic of_hit,
    input  logic ac_hit,
    output adv_e adv,
    output logic of_freeze,
    output logic ac_freeze,
    output logic in_ready
);
    always_comb begin
        if (of_hit) begin
            adv = ADV_OF_HOLD;
        end else if (ac_hit) begin
            adv = ADV_AC_HOLD;
        end else begin
            adv = ADV_ALL;
        end
        of_freeze = (adv == ADV_OF_HOLD);
        ac_freeze = (adv == ADV_AC_HOLD);
        in_ready  = (adv == ADV_ALL);
    end
endmodule

// File: rtl/ilk_pipe.sv
module ilk_pipe
    import ilk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               in_ready,
    output logic               of_freeze,
    output logic               ac_freeze,
    output logic [NSLOT-1:0]   stage_valid,
    output logic [ALU_W-1:0]   os_alu,
    output logic [MODE_W-1:0]  os_mode,
    output logic [REG_W-1:0]   os_r,
    output logic [REG_W-1:0]   os_x,
    output logic [EA_W-1:0]    os_ea,
    output logic               os_wr_reg,
    output logic               os_wr_mem
);
    pipe_t pipe_d, pipe_q;
    adv_e  adv;
    logic  of_hit, ac_hit;

    logic [NDN-1:0]             wr_reg;
    logic [NDN-1:0][REG_W-1:0]  reg_tag;
    logic [NMEM-1:0]            wr_mem;
    logic [NMEM-1:0][EA_W-1:0]  mem_tag;

    // writer predictions, index 0 is the slot nearest AC
    always_comb begin
        wr_reg[0]  = pipe_q.of.vld && pipe_q.of.mode[B_WR_REG];
        wr_reg[1]  = pipe_q.op.vld && pipe_q.op.mode[B_WR_REG];
        wr_reg[2]  = pipe_q.os.vld && pipe_q.os.mode[B_WR_REG];
        reg_tag[0] = pipe_q.of.r;
        reg_tag[1] = pipe_q.op.r;
        reg_tag[2] = pipe_q.os.r;
        wr_mem[0]  = pipe_q.op.vld && pipe_q.op.mode[B_WR_MEM];
        wr_mem[1]  = pipe_q.os.vld && pipe_q.os.mode[B_WR_MEM];
        mem_tag[0] = pipe_q.op.ea;
        mem_tag[1] = pipe_q.os.ea;
    end

    ilk_hazard u_hazard (
        .ac_need_idx (pipe_q.ac.vld && (pipe_q.ac.x != '0)),
        .ac_x        (pipe_q.ac.x),
        .of_need_reg (pipe_q.of.vld && pipe_q.of.mode[B_RD_REG]),
        .of_need_mem (pipe_q.of.vld && pipe_q.of.mode[B_RD_MEM]),
        .of_r        (pipe_q.of.r),
        .of_ea       (pipe_q.of.ea),
        .wr_reg      (wr_reg),
        .reg_tag     (reg_tag),
        .wr_mem      (wr_mem),
        .mem_tag     (mem_tag),
        .of_hit      (of_hit),
        .ac_hit      (ac_hit)
    );

    ilk_ctrl u_ctrl (
        .of_hit    (of_hit),
        .ac_hit    (ac_hit),
        .adv       (adv),
        .of_freeze (of_freeze),
        .ac_freeze (ac_freeze),
        .in_ready  (in_ready)
    );

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.os = pipe_q.op;
        case (adv)
            ADV_OF_HOLD: begin
                pipe_d.op = BUBBLE;
            end
            ADV_AC_HOLD: begin
                pipe_d.op = pipe_q.of;
                pipe_d.of = BUBBLE;
            end
            default: begin
                pipe_d.op = pipe_q.of;
                pipe_d.of = pipe_q.ac;
                pipe_d.ac = in_valid ? unpack_instr(in_instr) : BUBBLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        stage_valid = {pipe_q.os.vld, pipe_q.op.vld, pipe_q.of.vld, pipe_q.ac.vld};
        os_alu      = pipe_q.os.alu;
        os_mode     = pipe_q.os.mode;
        os_r        = pipe_q.os.r;
        os_x        = pipe_q.os.x;
        os_ea       = pipe_q.os.ea;
        os_wr_reg   = pipe_q.os.vld && pipe_q.os.mode[B_WR_REG];
        os_wr_mem   = pipe_q.os.vld && pipe_q.os.mode[B_WR_MEM];
    end
endmodule

// File: rtl/ilk_pipe_chk.sv
module ilk_pipe_chk
    import ilk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             of_freeze,
    input logic             ac_freeze,
    input logic [NSLOT-1:0] stage_valid,
    input logic             os_wr_reg,
    input logic             os_wr_mem
);
    // R6
    of_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        of_freeze |=> !stage_valid[2]);
    // R6
    of_hold_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
        of_freeze |=> stage_valid[1:0] == $past(stage_valid[1:0]));
    // R7
    ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ac_freeze |=> (!stage_valid[1] && stage_valid[0] == $past(stage_valid[0])));
    // R2
    os_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid[3] == $past(stage_valid[2]));
    // R9
    freeze_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({of_freeze, ac_freeze}));
    // R10
    os_write_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (os_wr_reg || os_wr_mem) |-> stage_valid[3]);
endmodule

bind ilk_pipe ilk_pipe_chk u_chk (.*);

// File: tb/ilk_pipe_tb.sv
module ilk_pipe_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        in_ready, of_freeze, ac_freeze, os_wr_reg, os_wr_mem;
    logic [3:0]  stage_valid, os_alu, os_mode, os_r, os_x;
    logic [15:0] os_ea;

    int n_chk = 0;
    int n_bad = 0;
    int ofc = 0;
    int acc = 0;

    // reference slots: 0 AC, 1 OF, 2 OP, 3 OS
    bit        mv  [4];
    bit [3:0]  malu[4];
    bit [3:0]  mm  [4];
    bit [3:0]  mr  [4];
    bit [3:0]  mx  [4];
    bit [15:0] mea [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ilk_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_ready(in_ready), .of_freeze(of_freeze), .ac_freeze(ac_freeze),
        .stage_valid(stage_valid), .os_alu(os_alu), .os_mode(os_mode),
        .os_r(os_r), .os_x(os_x), .os_ea(os_ea),
        .os_wr_reg(os_wr_reg), .os_wr_mem(os_wr_mem)
    );

    function automatic logic [31:0] mk(input bit [3:0] alu, input bit [3:0] mode,
                                       input bit [3:0] r, input bit [3:0] x,
                                       input bit [15:0] disp);
        return {alu, mode, r, x, disp};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_slot(input int i);
        mv[i] = 0; malu[i] = 0; mm[i] = 0; mr[i] = 0; mx[i] = 0; mea[i] = 0;
    endtask

    task automatic move_slot(input int from, input int to);
        mv[to] = mv[from]; malu[to] = malu[from]; mm[to] = mm[from];
        mr[to] = mr[from]; mx[to] = mx[from]; mea[to] = mea[from];
    endtask

    task automatic model_hz(output bit ofh, output bit ach);
        ofh = 0;
        ach = 0;
        for (int k = 2; k <= 3; k++) begin
            if (mv[1] && mm[1][3] && mv[k] && mm[k][1] && mr[k] == mr[1]) ofh = 1;
            if (mv[1] && mm[1][2] && mv[k] && mm[k][0] && mea[k] == mea[1]) ofh = 1;
        end
        for (int k = 1; k <= 3; k++) begin
            if (mv[0] && mx[0] != 0 && mv[k] && mm[k][1] && mr[k] == mx[0]) ach = 1;
        end
    endtask

    task automatic step(input bit v, input logic [31:0] w, output bit took);
        bit ofh, ach;
        string tag;
        in_valid = v;
        in_instr = w;
        #1;
        model_hz(ofh, ach);
        tag = (ofh && ach) ? "R9" : ofh ? "R6" : ach ? "R7" : "R12";
        chk(tag, "in_ready", int'(in_ready), int'(!(ofh || ach)));
        chk(tag, "of_freeze", int'(of_freeze), int'(ofh));
        chk(tag, "ac_freeze", int'(ac_freeze), int'(ach && !ofh));
        if (of_freeze) ofc++;
        if (ac_freeze) acc++;
        took = v && !(ofh || ach);
        @(posedge clk);
        move_slot(2, 3);
        if (ofh) begin
            clear_slot(2);
        end else if (ach) begin
            move_slot(1, 2);
            clear_slot(1);
        end else begin
            move_slot(1, 2);
            move_slot(0, 1);
            if (v) begin
                mv[0] = 1; malu[0] = w[31:28]; mm[0] = w[27:24];
                mr[0] = w[23:20]; mx[0] = w[19:16]; mea[0] = w[15:0];
            end else begin
                clear_slot(0);
            end
        end
        @(negedge clk);
        chk("R2", "stage_valid", int'(stage_valid), int'({mv[3], mv[2], mv[1], mv[0]}));
        chk("R2", "os_alu", int'(os_alu), int'(malu[3]));
        chk("R2", "os_mode", int'(os_mode), int'(mm[3]));
        chk("R2", "os_r", int'(os_r), int'(mr[3]));
        chk("R2", "os_x", int'(os_x), int'(mx[3]));
        chk("R2", "os_ea", int'(os_ea), int'(mea[3]));
        chk("R10", "os_wr_reg", int'(os_wr_reg), int'(mv[3] && mm[3][1]));
        chk("R10", "os_wr_mem", int'(os_wr_mem), int'(mv[3] && mm[3][0]));
    endtask

    task automatic send(input logic [31:0] w);
        bit took = 0;
        while (!took) step(1'b1, w, took);
    endtask

    task automatic idle(input int n);
        bit took;
        // offered word looks like a full read/write to r1 but is not valid
        for (int i = 0; i < n; i++) step(1'b0, mk(4'hF, 4'hF, 4'd1, 4'd1, 16'h0040), took);
    endtask

    task automatic expect_counts(input string req, input int e_of, input int e_ac);
        idle(6);
        chk(req, "operand-interlock cycles", ofc, e_of);
        chk(req, "index-interlock cycles", acc, e_ac);
        ofc = 0;
        acc = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) clear_slot(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "stage_valid", int'(stage_valid), 0);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "of_freeze", int'(of_freeze), 0);
        chk("R1", "ac_freeze", int'(ac_freeze), 0);
        @(negedge clk);

        // R2 R12: independent loads and store flow freely
        send(mk(4'h1, 4'b0110, 4'd1, 4'd0, 16'h0100));
        send(mk(4'h2, 4'b0110, 4'd2, 4'd0, 16'h0101));
        send(mk(4'h3, 4'b1001, 4'd3, 4'd0, 16'h0102));
        expect_counts("R12", 0, 0);

        // R3 R11: load r1 then store r1 directly
        send(mk(4'h1, 4'b0110, 4'd1, 4'd0, 16'h0010));
        send(mk(4'h4, 4'b1001, 4'd1, 4'd0, 16'h0020));
        expect_counts("R11", 2, 0);

        // R4 R11: one independent instruction between
        send(mk(4'h1, 4'b0110, 4'd1, 4'd0, 16'h0010));
        send(mk(4'h5, 4'b0010, 4'd5, 4'd0, 16'h0007));
        send(mk(4'h4, 4'b1001, 4'd1, 4'd0, 16'h0020));
        expect_counts("R4", 1, 0);

        // R5: store to memory then load from same address
        send(mk(4'h6, 4'b1001, 4'd1, 4'd0, 16'h0040));
        send(mk(4'h7, 4'b0110, 4'd2, 4'd0, 16'h0040));
        expect_counts("R5", 2, 0);

        // R5 R12: different addresses do not interlock
        send(mk(4'h6, 4'b1001, 4'd1, 4'd0, 16'h0040));
        send(mk(4'h7, 4'b0110, 4'd2, 4'd0, 16'h0041));
        expect_counts("R5", 0, 0);

        // R7: index register written just ahead
        send(mk(4'h1, 4'b0110, 4'd4, 4'd0, 16'h0010));
        send(mk(4'h2, 4'b0010, 4'd6, 4'd4, 16'h0003));
        expect_counts("R7", 0, 3);

        // R8: x = 0 behind a write to register 0
        send(mk(4'h1, 4'b0110, 4'd0, 4'd0, 16'h0010));
        send(mk(4'h2, 4'b0010, 4'd6, 4'd0, 16'h0003));
        expect_counts("R8", 0, 0);

        // R9: both interlocks in the same cycle
        send(mk(4'h1, 4'b0110, 4'd1, 4'd0, 16'h0010));
        send(mk(4'h4, 4'b1001, 4'd1, 4'd0, 16'h0020));
        send(mk(4'h2, 4'b0010, 4'd7, 4'd1, 16'h0005));
        expect_counts("R9", 2, 0);

        // R10: invalid word that looks like a write to r1 ahead of a reader
        idle(1);
        send(mk(4'h4, 4'b1001, 4'd1, 4'd0, 16'h0040));
        expect_counts("R10", 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule